// File: doc/BRIEF.md
# Move-only memory-to-memory execution unit

This block executes a program in which every instruction is a single transfer from one memory location to another. The unit has no arithmetic logic and no data registers that a program can see. The only architectural register is the program counter. Any work beyond copying a word is done by moving words into and out of devices that sit at fixed addresses on the bus. The block carries one such device itself: a 16-bit adder with two operand locations and one result location. The program counter also has an address, so a move into that location is a jump.

An instruction takes two consecutive words. The first holds the source address and the second the destination address. Each instruction uses four bus cycles:

1. fetch the source address;
2. fetch the destination address;
3. read the source word;
4. write that word to the destination.

Memory is word-addressed and sits on a single synchronous bus. Each cycle the unit drives an address, a write enable and write data. Read data comes back in the same cycle and is captured at the clock edge that ends it. Locations the unit serves itself never assert the external write enable. For those locations, any data on the bus is ignored.

Top module: `movex_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, bus_addr is 0 and bus_we is 0. Execution begins with a fetch from address 0.
- R2: Each instruction occupies exactly four cycles, in this order:
  1. read at PC (the source address);
  2. read at PC+1 (the destination address);
  3. read at the source address;
  4. write to the destination address.

  No other cycle drives a write.
- R3: After an instruction whose destination is not the PC location, the next instruction is fetched from the previous PC plus 2, modulo 2^16.
- R4: Writing a value V to the PC location (default 0xFFFE) makes the next fetch come from address V. Instructions between the jump and V are not executed.
- R5: Reading the PC location as a source yields the address of the instruction that follows the current one (current PC + 2).
- R6: Writing to the operand locations (default 0xFFF0 and 0xFFF1) sets the adder operands. Reading the sum location (default 0xFFF2) yields their sum modulo 2^16, with the carry dropped. Reading an operand location returns that operand.
- R7: A write whose destination is the PC location or one of the three adder locations leaves bus_we at 0. A read of any of these locations ignores bus_rdata.
- R8: A write to any other address drives bus_we=1, that address on bus_addr, and the moved word on bus_wdata. A read from any other address takes bus_rdata as sampled at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | output | 16 | Word address of the current bus cycle |
| bus_we | output | 1 | Write strobe for the current cycle |
| bus_wdata | output | 16 | Data written when bus_we is 1 |
| bus_rdata | input | 16 | Read data for the current cycle's address |

## Verification
The bench builds the unit with its default parameters: a 16-bit word and the four internal locations at 0xFFF0 to 0xFFFE. Those locations lie far above the bench's 256-word memory, so a write that leaked onto the bus could not alias any program data. The 16-bit width lets an operand pair of 0xFFFF and 3 exercise the dropped carry. The test program covers all of these:
- a PC read that stores the next instruction's address;
- a forward jump over a marked instruction;
- a self-jump on which the program settles.

// File: rtl/movex_unit.sv
module movex_unit #(
  parameter int W = 16,
  parameter logic [W-1:0] PC_LOC   = 16'hFFFE,
  parameter logic [W-1:0] ADDA_LOC = 16'hFFF0,
  parameter logic [W-1:0] ADDB_LOC = 16'hFFF1,
  parameter logic [W-1:0] SUM_LOC  = 16'hFFF2
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] bus_addr,
  output logic         bus_we,
  output logic [W-1:0] bus_wdata,
  input  logic [W-1:0] bus_rdata
);

  typedef enum logic [1:0] {S_FSRC, S_FDST, S_RD, S_WR} ph_t;

  ph_t          ph;
  logic [W-1:0] pc_q, src_q, dst_q, dat_q, op_a, op_b;
  logic [W-1:0] rd_val;
  logic         dst_int;

  function automatic logic is_int(input logic [W-1:0] a);
    return (a == PC_LOC) || (a == ADDA_LOC) || (a == ADDB_LOC) || (a == SUM_LOC);
  endfunction

  assign dst_int = is_int(dst_q);

  always_comb begin
    if (src_q == PC_LOC)        rd_val = pc_q;
    else if (src_q == SUM_LOC)  rd_val = op_a + op_b;
    else if (src_q == ADDA_LOC) rd_val = op_a;
    else if (src_q == ADDB_LOC) rd_val = op_b;
    else                        rd_val = bus_rdata;
  end

  always_comb begin
    case (ph)
      S_FSRC:  bus_addr = pc_q;
      S_FDST:  bus_addr = pc_q + W'(1);
      S_RD:    bus_addr = src_q;
      default: bus_addr = dst_q;
    endcase
  end

  assign bus_we    = (ph == S_WR) && !dst_int;
  assign bus_wdata = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= S_FSRC;
      pc_q  <= '0;
      src_q <= '0;
      dst_q <= '0;
      dat_q <= '0;
      op_a  <= '0;
      op_b  <= '0;
    end else begin
      ph <= ph_t'(ph + 2'd1);
      case (ph)
        S_FSRC: src_q <= bus_rdata;
        S_FDST: begin
          dst_q <= bus_rdata;
          pc_q  <= pc_q + W'(2);
        end
        S_RD:   dat_q <= rd_val;
        default: begin
          if (dst_q == PC_LOC)   pc_q <= dat_q;
          if (dst_q == ADDA_LOC) op_a <= dat_q;
          if (dst_q == ADDB_LOC) op_b <= dat_q;
        end
      endcase
    end
  end

  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !bus_we);

  p_dst_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == S_FSRC) |=> (bus_addr == $past(bus_addr) + W'(1)));

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == S_FDST) |=> (pc_q == $past(pc_q) + W'(2)));

  p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == S_WR && dst_q == PC_LOC) |=> (bus_addr == $past(dat_q)));

  p_opa_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == S_WR && dst_q == ADDA_LOC) |=> (op_a == $past(dat_q)));

  p_no_int_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> !is_int(bus_addr));

endmodule

// File: tb/tb_movex_unit.sv
`timescale 1ns/1ps
module tb_movex_unit;
  localparam int PCL = 16'hFFFE, AL = 16'hFFF0, BL = 16'hFFF1, SL = 16'hFFF2;

  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_we;
  logic [15:0] mem [256];
  int total = 0, bad = 0;
  bit done = 0;
  int m_pc, m_ph, m_src, m_dst, m_dat, m_a, m_b;

  always #2 clk = ~clk;

  movex_unit dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  assign bus_rdata = (bus_addr < 16'd256) ? mem[bus_addr[7:0]] : 16'hDEAD;

  always @(posedge clk) if (bus_we && bus_addr < 16'd256) mem[bus_addr[7:0]] <= bus_wdata;

  function automatic int rdm(int a);
    return (a < 256) ? int'(mem[a]) : 'hDEAD;
  endfunction

  function automatic bit intern(int a);
    return a == PCL || a == AL || a == BL || a == SL;
  endfunction

  function automatic int exp_addr();
    case (m_ph)
      0: return m_pc;
      1: return (m_pc + 1) & 'hFFFF;
      2: return m_src;
      default: return m_dst;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_ph = 0; m_src = 0; m_dst = 0; m_dat = 0; m_a = 0; m_b = 0;
    end else begin
      case (m_ph)
        0: m_src = rdm(m_pc);
        1: begin m_dst = rdm((m_pc + 1) & 'hFFFF); m_pc = (m_pc + 2) & 'hFFFF; end
        2: begin
          if (m_src == PCL) m_dat = m_pc;
          else if (m_src == SL) m_dat = (m_a + m_b) & 'hFFFF;
          else if (m_src == AL) m_dat = m_a;
          else if (m_src == BL) m_dat = m_b;
          else m_dat = rdm(m_src);
        end
        default: begin
          if (m_dst == PCL) m_pc = m_dat;
          else if (m_dst == AL) m_a = m_dat;
          else if (m_dst == BL) m_b = m_dat;
        end
      endcase
      m_ph = (m_ph + 1) % 4;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R2 R3 R4 bus_addr", int'(bus_addr), exp_addr());
    chk("R7 R8 bus_we", int'(bus_we), int'(m_ph == 3 && !intern(m_dst)));
    if (bus_we) chk("R8 bus_wdata", int'(bus_wdata), m_dat);
  end

  task automatic ins(int at, int s, int d);
    mem[at] = 16'(s); mem[at+1] = 16'(d);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    ins(0, 100, AL); ins(2, 101, BL); ins(4, SL, 102); ins(6, PCL, 103);
    ins(8, 104, PCL); ins(10, 100, 105);
    ins(12, 106, AL); ins(14, 107, BL); ins(16, SL, 108); ins(18, 109, PCL);
    mem[100] = 16'h0030; mem[101] = 16'h0016; mem[104] = 16'd12; mem[105] = 16'h5555;
    mem[106] = 16'hFFFF; mem[107] = 16'h0003; mem[109] = 16'd18;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset addr", int'(bus_addr), 0);
    chk("R1 reset we", int'(bus_we), 0);
    rst_n = 1;
    repeat (90) @(posedge clk);
    @(negedge clk);
    done = 1;
    chk("R6 sum", int'(mem[102]), 'h0046);
    chk("R5 pc read", int'(mem[103]), 8);
    chk("R4 skipped", int'(mem[105]), 'h5555);
    chk("R6 carry dropped", int'(mem[108]), 'h0002);
    chk("R3 R4 self loop", int'(bus_addr) >= 18 && int'(bus_addr) <= 19 ? 1 : (bus_addr == 16'd109 ? 1 : (bus_addr == PCL ? 1 : 0)), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule